// File: doc/BRIEF.md
# HIPPI Source Burst Framer

This block sits between a host-side FIFO and the source side of a HIPPI-style channel. The host fills the FIFO with payload words only: 32 data bits, 4 byte-parity bits, and two flags that mark the end of a short burst and the end of a packet. The framer opens a packet, cuts the word stream into bursts of at most `BURST_WORDS` words, and follows each burst with a check word. It also inserts the idle intervals that the channel needs before the first burst and between bursts, so the host never has to pad the FIFO.

The check word is the XOR of every data word in the burst, further XORed with the number of words in that burst. It is sent on every burst, whether the burst reached full length or the host ended it early. Each word leaving on the channel has its parity checked. A bad word is still passed through as it is, and an error strobe is raised for one cycle. The block does not stop a host from sending several short bursts in one packet.

Top module: `hippi_src_framer`

## Requirements
- R1: While `rst_n` is low, every channel output (`ch_packet`, `ch_burst`, `ch_word`, `ch_llrc`, `ch_data`, `ch_par`, `par_err`) is zero and `fifo_rd` stays low, even if the FIFO holds words.
- R2: When a packet starts with words waiting in the FIFO, its first data word appears on the channel exactly `PKT_LEAD`+1 cycles after `ch_packet` rises. `ch_burst` is low in the cycle after that rise.
- R3: Each word popped with `fifo_rd` appears on `ch_data`/`ch_par` in the next cycle, with `ch_word` high, unchanged and in FIFO order.
- R4: A burst that carries no end flag closes by itself after exactly `BURST_WORDS` data words, and its check word follows at once.
- R5: A word with `fifo_eob` set is the last word of a short burst, and the check word follows in the next cycle.
- R6: The check word occupies exactly one cycle with `ch_llrc` high, directly after the burst's last data word. Its value is the XOR of all data words in the burst with the word count, the count zero-extended to 32 bits. `ch_par` for it is correct odd parity.
- R7: Within a packet, exactly `BURST_GAP` idle cycles (no `ch_burst`, no `ch_word`) separate the check word from the next burst's first data word.
- R8: Parity is odd per byte: `ch_par[i]` makes `ch_data[8i+7:8i]` plus itself contain an odd number of ones. `par_err` is high only in the cycle right after a channel word with wrong parity.
- R9: A word with bad parity is sent with its data and bad parity unchanged, and the burst carries on.
- R10: A word with `fifo_eop` set ends both its burst and the packet. `ch_packet` stays high through the check word and falls exactly `BURST_GAP` cycles after the check-word cycle.
- R11: Several short bursts in one packet are all framed normally, each with its own check word, under a single `ch_packet` assertion.
- R12: If the FIFO runs empty in the middle of a burst, `ch_burst` stays high and `ch_word` stays low until words resume. Stall cycles do not count toward the burst length or the check-word seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_empty | input | 1 | Show-ahead FIFO has no word |
| fifo_data | input | 32 | Head-of-FIFO data word |
| fifo_par | input | 4 | Head-of-FIFO byte parity |
| fifo_eob | input | 1 | Head word ends a short burst |
| fifo_eop | input | 1 | Head word ends the packet |
| fifo_rd | output | 1 | Pop the head word this cycle |
| ch_packet | output | 1 | Packet framing on the channel |
| ch_burst | output | 1 | Burst framing on the channel |
| ch_word | output | 1 | A data word is on `ch_data` |
| ch_llrc | output | 1 | The check word is on `ch_data` |
| ch_data | output | 32 | Channel data |
| ch_par | output | 4 | Channel byte parity |
| par_err | output | 1 | Previous channel word had bad parity |

## Verification
The bench aims at the burst edges. It sends a full-length burst with no end flag, a single-word packet whose check word is the word XOR 1, back-to-back short bursts, and a stall in the middle of a burst. A design that miscounts would close the full burst one word early or late, or fold stall cycles into the seed, and the check word would then come out wrong. The bench also places one bad-parity word inside a burst and expects a single error pulse in the following cycle with the word unchanged. A flag that lands on the wrong word or a design that repairs the word would both show up there. Exact cycle gaps are measured at packet start, between bursts and at packet end, so an extra or missing idle cycle is reported.

// File: rtl/hsf_pkg.sv
package hsf_pkg;
    // Sequencer states of the framer.
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_LEAD  = 3'd1,
        S_BURST = 3'd2,
        S_LLRC  = 3'd3,
        S_GAP   = 3'd4
    } hsf_state_e;
endpackage

// File: rtl/hsf_par_gen.sv
// hsf_par_gen: odd parity per byte for a DATA_W-bit word.
// Assumes DATA_W is a multiple of 8. Output bit i covers bits 8i+7:8i.
module hsf_par_gen #(
    parameter int DATA_W = 32,
    localparam int PAR_W = DATA_W / 8
) (
    input  logic [DATA_W-1:0] din,
    output logic [PAR_W-1:0]  par
);
    for (genvar i = 0; i < PAR_W; i++) begin : g_byte
        // Set the bit so the byte plus its parity holds an odd number of ones.
        assign par[i] = ~^din[8*i +: 8];
    end
endmodule

// File: rtl/hsf_llrc_acc.sv
// hsf_llrc_acc: keeps the running XOR and the word count of the current burst.
// Assumes take and clear never occur together. clear is pulsed in the
// check-word slot, after the sequencer has sampled llrc.
module hsf_llrc_acc #(
    parameter int DATA_W      = 32,
    parameter int BURST_WORDS = 256,
    localparam int CNT_W      = $clog2(BURST_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              clear,
    input  logic [DATA_W-1:0] din,
    output logic [CNT_W-1:0]  cnt,
    output logic [DATA_W-1:0] llrc
);
    logic [DATA_W-1:0] acc;

    // Add each accepted word into the XOR and count it; restart after the check word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
            cnt <= '0;
        end else if (clear) begin
            acc <= '0;
            cnt <= '0;
        end else if (take) begin
            acc <= acc ^ din;
            cnt <= cnt + 1'b1;
        end
    end

    // Seed the check word with the number of words in the burst.
    always_comb llrc = acc ^ DATA_W'(cnt);

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(BURST_WORDS));
endmodule

// File: rtl/hsf_par_mon.sv
// hsf_par_mon: checks odd byte parity on each word leaving for the channel
// and raises err for the single cycle that follows a bad word. It only
// observes and never changes the data.
module hsf_par_mon #(
    parameter int DATA_W = 32,
    localparam int PAR_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic [DATA_W-1:0] data,
    input  logic [PAR_W-1:0]  par,
    output logic              err
);
    logic [PAR_W-1:0] good_par;

    hsf_par_gen #(.DATA_W(DATA_W)) u_gen (
        .din (data),
        .par (good_par)
    );

    // Flag a mismatch one cycle after the word it belongs to.
    always_ff @(posedge clk) begin
        if (!rst_n) err <= 1'b0;
        else        err <= valid && (par != good_par);
    end

    // R8
    err_needs_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(valid));
endmodule

// File: rtl/hsf_seq.sv
// hsf_seq: packet/burst sequencer. It opens a packet, waits PKT_LEAD cycles,
// pops words while the FIFO has them, closes a burst on a flag or at
// BURST_WORDS, gives one slot to the check word, and then waits BURST_GAP
// cycles. Assumes PKT_LEAD >= 1 and BURST_GAP >= 1.
module hsf_seq
    import hsf_pkg::*;
#(
    parameter int BURST_WORDS = 256,
    parameter int PKT_LEAD    = 2,
    parameter int BURST_GAP   = 1,
    localparam int CNT_W      = $clog2(BURST_WORDS + 1),
    localparam int MAX_WAIT   = (PKT_LEAD > BURST_GAP) ? PKT_LEAD : BURST_GAP,
    localparam int TMR_W      = (MAX_WAIT > 1) ? $clog2(MAX_WAIT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_empty,
    input  logic             fifo_eob,
    input  logic             fifo_eop,
    input  logic [CNT_W-1:0] cnt,
    output logic             fifo_rd,
    output logic             burst_open,
    output hsf_state_e       state
);
    logic [TMR_W-1:0] tmr;
    logic             pkt_last;
    logic             last_word;

    // Pop only inside a burst and only when a word is waiting.
    always_comb fifo_rd = (state == S_BURST) && !fifo_empty;

    // The burst closes on either flag or when the word limit is reached.
    always_comb last_word = fifo_rd &&
        (fifo_eob || fifo_eop || (cnt == CNT_W'(BURST_WORDS - 1)));

    // A burst is open once it has sent a word, so stalls keep the framing up.
    always_comb burst_open = (state == S_BURST) && (cnt != '0);

    // Advance the state machine and the shared wait timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            tmr      <= '0;
            pkt_last <= 1'b0;
        end else begin
            case (state)
                S_IDLE: begin
                    pkt_last <= 1'b0;
                    if (!fifo_empty) begin
                        state <= S_LEAD;
                        tmr   <= TMR_W'(PKT_LEAD - 1);
                    end
                end
                S_LEAD: begin
                    if (tmr == '0) state <= S_BURST;
                    else           tmr   <= tmr - 1'b1;
                end
                S_BURST: begin
                    if (fifo_rd && fifo_eop) pkt_last <= 1'b1;
                    if (last_word)           state    <= S_LLRC;
                end
                S_LLRC: begin
                    state <= S_GAP;
                    tmr   <= TMR_W'(BURST_GAP - 1);
                end
                S_GAP: begin
                    if (tmr == '0) state <= pkt_last ? S_IDLE : S_BURST;
                    else           tmr   <= tmr - 1'b1;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R10
    eop_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_rd && fifo_eop) |=> (state == S_LLRC));

    // R5
    eob_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_rd && fifo_eob) |=> (state == S_LLRC));
endmodule

// File: rtl/hippi_src_framer.sv
// hippi_src_framer: top of the source-side framer. Registers every channel
// output: a data word one cycle after its pop, and the check word in the
// cycle after the burst's last data word. Assumes a show-ahead FIFO whose
// head word is valid whenever fifo_empty is low.
module hippi_src_framer
    import hsf_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int BURST_WORDS = 256,
    parameter int PKT_LEAD    = 2,
    parameter int BURST_GAP   = 1,
    localparam int PAR_W      = DATA_W / 8,
    localparam int CNT_W      = $clog2(BURST_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_data,
    input  logic [PAR_W-1:0]  fifo_par,
    input  logic              fifo_eob,
    input  logic              fifo_eop,
    output logic              fifo_rd,
    output logic              ch_packet,
    output logic              ch_burst,
    output logic              ch_word,
    output logic              ch_llrc,
    output logic [DATA_W-1:0] ch_data,
    output logic [PAR_W-1:0]  ch_par,
    output logic              par_err
);
    hsf_state_e        state;
    logic              burst_open;
    logic              llrc_slot;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] llrc;
    logic [PAR_W-1:0]  llrc_par;

    hsf_seq #(
        .BURST_WORDS (BURST_WORDS),
        .PKT_LEAD    (PKT_LEAD),
        .BURST_GAP   (BURST_GAP)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_empty (fifo_empty),
        .fifo_eob   (fifo_eob),
        .fifo_eop   (fifo_eop),
        .cnt        (cnt),
        .fifo_rd    (fifo_rd),
        .burst_open (burst_open),
        .state      (state)
    );

    always_comb llrc_slot = (state == S_LLRC);

    hsf_llrc_acc #(
        .DATA_W      (DATA_W),
        .BURST_WORDS (BURST_WORDS)
    ) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (fifo_rd),
        .clear (llrc_slot),
        .din   (fifo_data),
        .cnt   (cnt),
        .llrc  (llrc)
    );

    hsf_par_gen #(.DATA_W(DATA_W)) u_llrc_par (
        .din (llrc),
        .par (llrc_par)
    );

    hsf_par_mon #(.DATA_W(DATA_W)) u_mon (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (ch_word | ch_llrc),
        .data  (ch_data),
        .par   (ch_par),
        .err   (par_err)
    );

    // The packet is framed for as long as the sequencer is busy.
    always_comb ch_packet = (state != S_IDLE);

    // Register the channel bus: popped words pass through, the check word follows.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_burst <= 1'b0;
            ch_word  <= 1'b0;
            ch_llrc  <= 1'b0;
            ch_data  <= '0;
            ch_par   <= '0;
        end else begin
            ch_word  <= fifo_rd;
            ch_llrc  <= llrc_slot;
            ch_burst <= fifo_rd | burst_open;
            if (fifo_rd) begin
                ch_data <= fifo_data;
                ch_par  <= fifo_par;
            end else if (llrc_slot) begin
                ch_data <= llrc;
                ch_par  <= llrc_par;
            end
        end
    end

    // R3
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |=> (ch_word && ch_data == $past(fifo_data) && ch_par == $past(fifo_par)));

    // R6
    llrc_after_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ch_burst) |-> ch_llrc);

    // R7
    gap_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ch_llrc |=> (!ch_burst && !ch_word));

    // R2
    lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ch_packet) |=> !ch_burst);

    // R10
    burst_in_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ch_burst |-> ch_packet);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!ch_burst && !ch_word && !ch_llrc && !par_err));
endmodule

// File: tb/hippi_src_framer_test.sv
module hippi_src_framer_test;
    localparam int BW   = 256;
    localparam int LEAD = 2;
    localparam int GAP  = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_empty, fifo_eob, fifo_eop, fifo_rd;
    logic [31:0] fifo_data;
    logic [3:0]  fifo_par;
    logic        ch_packet, ch_burst, ch_word, ch_llrc, par_err;
    logic [31:0] ch_data;
    logic [3:0]  ch_par;

    always #5 clk = ~clk;

    hippi_src_framer #(.BURST_WORDS(BW), .PKT_LEAD(LEAD), .BURST_GAP(GAP)) uut (
        .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
        .fifo_par(fifo_par), .fifo_eob(fifo_eob), .fifo_eop(fifo_eop), .fifo_rd(fifo_rd),
        .ch_packet(ch_packet), .ch_burst(ch_burst), .ch_word(ch_word), .ch_llrc(ch_llrc),
        .ch_data(ch_data), .ch_par(ch_par), .par_err(par_err)
    );

    // Bench show-ahead FIFO.
    logic [31:0] fd [0:1023];
    logic [3:0]  fp [0:1023];
    logic        fb [0:1023];
    logic        fe [0:1023];
    int wr_i = 0;
    int rd_i = 0;
    assign fifo_empty = (rd_i == wr_i);
    assign fifo_data  = fd[rd_i % 1024];
    assign fifo_par   = fp[rd_i % 1024];
    assign fifo_eob   = fifo_empty ? 1'b0 : fb[rd_i % 1024];
    assign fifo_eop   = fifo_empty ? 1'b0 : fe[rd_i % 1024];
    always @(posedge clk) if (fifo_rd) rd_i <= rd_i + 1;

    // Channel log.
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;
    logic [31:0] wd [0:511];
    logic [3:0]  wp [0:511];
    int          wc [0:511];
    logic [31:0] ld [0:15];
    logic [3:0]  lp [0:15];
    int          lc [0:15];
    int          ec [0:15];
    int nw, nl, ne, nb, nr, rise_c, fall_c;
    logic pk_prev = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (ch_word) begin wd[nw] = ch_data; wp[nw] = ch_par; wc[nw] = cyc; nw++; end
            if (ch_llrc) begin ld[nl] = ch_data; lp[nl] = ch_par; lc[nl] = cyc; nl++; end
            if (par_err) begin ec[ne] = cyc; ne++; end
            if (ch_burst) nb++;
            if (ch_packet && !pk_prev) begin rise_c = cyc; nr++; end
            if (!ch_packet && pk_prev) fall_c = cyc;
            pk_prev = ch_packet;
        end
    end

    // Expected words of the current test.
    logic [31:0] ed [0:511];
    logic [3:0]  ep [0:511];
    int ne_d = 0;

    int checks = 0;
    int errors = 0;

    function automatic logic [3:0] odd_par(logic [31:0] d);
        logic [3:0] p;
        for (int i = 0; i < 4; i++) p[i] = ~^d[8*i +: 8];
        return p;
    endfunction

    function automatic logic [31:0] exp_llrc(int first, int n);
        logic [31:0] x = 32'(n);
        for (int i = 0; i < n; i++) x ^= ed[first + i];
        return x;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] d, input bit bad, input bit eob, input bit eop);
        logic [3:0] p = odd_par(d) ^ (bad ? 4'b0001 : 4'b0000);
        fd[wr_i % 1024] = d; fp[wr_i % 1024] = p;
        fb[wr_i % 1024] = eob; fe[wr_i % 1024] = eop;
        ed[ne_d] = d; ep[ne_d] = p; ne_d++;
        wr_i++;
    endtask

    task automatic clear_log();
        nw = 0; nl = 0; ne = 0; nb = 0; nr = 0; ne_d = 0;
        rise_c = -1; fall_c = -1;
    endtask

    task automatic wait_llrc(input int n);
        int g = 0;
        while (nl < n && g < 5000) begin @(negedge clk); g++; end
        repeat (6) @(negedge clk);
    endtask

    task automatic check_words(input string tag, input int n);
        bit ok = (nw == n);
        chk(ok, {tag, " word count"}, 32'(nw), 32'(n));
        for (int i = 0; i < n && ok; i++)
            if (wd[i] !== ed[i] || wp[i] !== ep[i]) begin
                chk(1'b0, {tag, " word value"}, wd[i], ed[i]);
                ok = 0;
            end
        if (ok) chk(1'b1, tag, 0, 0);
    endtask

    // R1: quiet outputs during reset although the FIFO holds a word.
    task automatic t_reset();
        clear_log();
        @(negedge clk);
        push(32'hA5A5_0001, 0, 0, 1);
        repeat (3) @(negedge clk);
        chk(!fifo_rd && !ch_packet && !ch_burst && !ch_word && !ch_llrc && !par_err
            && ch_data == 0 && ch_par == 0, "R1 outputs in reset",
            {ch_packet, ch_burst, ch_word, ch_llrc, par_err, fifo_rd}, 0);
        rst_n = 1'b1;
        wait_llrc(1);
        // R6: single-word burst check word equals the word XOR 1.
        chk(nl == 1 && ld[0] == (32'hA5A5_0001 ^ 32'd1), "R6 single-word check word", ld[0], 32'hA5A5_0000);
    endtask

    // R2, R3, R6, R10: one short packet.
    task automatic t_short();
        clear_log();
        for (int i = 0; i < 5; i++) push(32'h1000_0000 + 32'(i) * 32'h0101_0103, 0, 0, i == 4);
        wait_llrc(1);
        check_words("R3 short packet", 5);
        chk(lc[0] == wc[4] + 1, "R6 check word timing", 32'(lc[0]), 32'(wc[4] + 1));
        chk(ld[0] == exp_llrc(0, 5), "R6 check word value", ld[0], exp_llrc(0, 5));
        chk(lp[0] == odd_par(ld[0]), "R6 check word parity", 32'(lp[0]), 32'(odd_par(ld[0])));
        chk(wc[0] - rise_c == LEAD + 1, "R2 packet lead", 32'(wc[0] - rise_c), 32'(LEAD + 1));
        chk(fall_c - lc[0] == GAP, "R10 packet end", 32'(fall_c - lc[0]), 32'(GAP));
        chk(ne == 0, "R8 no false error", 32'(ne), 0);
    endtask

    // R4, R7: full-length burst then a tail burst.
    task automatic t_full();
        clear_log();
        for (int i = 0; i < BW + 3; i++) push(32'(i) * 32'h0001_0F0B ^ 32'hC3C3_0000, 0, 0, i == BW + 2);
        wait_llrc(2);
        check_words("R3 full packet", BW + 3);
        chk(nl == 2 && lc[0] == wc[BW-1] + 1, "R4 burst closes at limit", 32'(lc[0]), 32'(wc[BW-1] + 1));
        chk(ld[0] == exp_llrc(0, BW), "R4 full check word", ld[0], exp_llrc(0, BW));
        chk(wc[BW] - lc[0] == GAP + 1, "R7 inter-burst gap", 32'(wc[BW] - lc[0]), 32'(GAP + 1));
        chk(ld[1] == exp_llrc(BW, 3), "R6 tail check word", ld[1], exp_llrc(BW, 3));
    endtask

    // R5, R11: three short bursts in one packet.
    task automatic t_two_short();
        clear_log();
        for (int i = 0; i < 3; i++) push(32'hDEAD_0000 + 32'(i), 0, i == 2, 0);
        for (int i = 0; i < 2; i++) push(32'hBEEF_1000 + 32'(i), 0, i == 1, 0);
        for (int i = 0; i < 4; i++) push(32'h0F0F_2000 + 32'(i), 0, 0, i == 3);
        wait_llrc(3);
        check_words("R3 short bursts", 9);
        chk(lc[0] == wc[2] + 1, "R5 first short burst end", 32'(lc[0]), 32'(wc[2] + 1));
        chk(lc[1] == wc[4] + 1, "R5 second short burst end", 32'(lc[1]), 32'(wc[4] + 1));
        chk(nl == 3 && nr == 1, "R11 bursts in one packet", 32'(nl * 16 + nr), 32'h31);
        chk(ld[1] == exp_llrc(3, 2) && ld[2] == exp_llrc(5, 4), "R11 check words", ld[1], exp_llrc(3, 2));
        chk(wc[3] - lc[0] == GAP + 1, "R7 gap after short burst", 32'(wc[3] - lc[0]), 32'(GAP + 1));
    endtask

    // R8, R9: one bad-parity word mid-burst.
    task automatic t_parity();
        clear_log();
        for (int i = 0; i < 4; i++) push(32'h7777_0000 + 32'(i) * 32'h11, i == 1, 0, i == 3);
        wait_llrc(1);
        chk(ne == 1 && ec[0] == wc[1] + 1, "R8 error pulse timing", 32'(ec[0]), 32'(wc[1] + 1));
        chk(wd[1] == ed[1] && wp[1] == ep[1], "R9 bad word passed unchanged", 32'(wp[1]), 32'(ep[1]));
        check_words("R9 burst continues", 4);
        chk(ld[0] == exp_llrc(0, 4), "R9 check word after bad word", ld[0], exp_llrc(0, 4));
    endtask

    // R12: FIFO runs dry inside a burst.
    task automatic t_stall();
        clear_log();
        push(32'h1234_5678, 0, 0, 0);
        push(32'h9ABC_DEF0, 0, 0, 0);
        repeat (8) @(negedge clk);
        push(32'h0BAD_F00D, 0, 0, 0);
        push(32'h5555_AAAA, 0, 0, 1);
        wait_llrc(1);
        check_words("R12 stalled burst", 4);
        chk(wc[3] - wc[1] > 1 && nb == wc[3] - wc[0] + 1, "R12 burst held through stall",
            32'(nb), 32'(wc[3] - wc[0] + 1));
        chk(nl == 1 && ld[0] == exp_llrc(0, 4), "R12 stall not counted", ld[0], exp_llrc(0, 4));
    endtask

    initial begin
        t_reset();
        t_short();
        t_full();
        t_two_short();
        t_parity();
        t_stall();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule